// File: doc/BRIEF.md
# Selectable-Width Masked Interrupt Down-Counter

This block is a cycle-driven interrupt timer built around a 16-bit down-counter. On every cycle in which the tick input is high and the timer is enabled, the counter steps down by one. A control write narrows the active field to the low 16, 12, 8 or 4 bits. Only the active field takes part in the decrement and in the zero test. The bits above it keep their value.

Software-side logic loads four 4-bit reload registers through an indexed write port. A reload strobe copies the assembled 16-bit value into the counter. A control write sets the enable and the width. The interrupt output is a sticky level: it is raised when an enabled tick finds the active field at zero, and it is cleared by either a reload strobe or a control write. Address decoding and the processor itself sit outside the block.

Top module: `masked_irq_timer`

## Requirements
- R1: After reset, irq is 0, count is 0x0000, the timer is disabled, the width is the full 16 bits and every reload register holds zero, so a reload strobe loads 0x0000.
- R2: A reload-register write (relWr high) stores wrData[3:0] into the nibble chosen by relIdx, where index 0 feeds bits 3:0 and index 3 feeds bits 15:12. wrData[7:4] is ignored.
- R3: A reload strobe sets count to the assembled reload value on the next cycle and clears irq. A reload-register write in the same cycle is not yet seen by that strobe.
- R4: A control write (ctrlWr high) clears irq and sets the enable from wrData[0]. The new enable and width apply from the following cycle.
- R5: The control write picks the width by priority: wrData[3] gives 4 bits (mask 0x000F), else wrData[2] gives 8 bits (mask 0x00FF), else wrData[1] gives 12 bits (mask 0x0FFF), else 16 bits (mask 0xFFFF). Bits 7:4 have no effect.
- R6: On an enabled tick, the masked bits of count decrement by one with wraparound inside the mask, and the bits outside the mask stay unchanged.
- R7: An enabled tick that finds the masked bits at zero raises irq on the next cycle, and the masked bits wrap to all ones.
- R8: Once raised, irq stays high until a reload strobe or a control write.
- R9: While the timer is disabled, ticks leave count unchanged and do not raise irq.
- R10: A reload strobe or a control write in the same cycle as an enabled tick overrides that tick. No decrement happens from the tick, and irq ends low even if the masked bits were zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable for one cycle |
| relWr | input | 1 | Write strobe for one reload nibble |
| relIdx | input | 2 | Reload nibble index |
| wrData | input | 8 | Write data for reload and control writes |
| relLoad | input | 1 | Reload strobe: copy the reload value into the counter |
| ctrlWr | input | 1 | Control write: enable in bit 0, width in bits 3:1 |
| irq | output | 1 | Sticky interrupt request level |
| count | output | 16 | Current counter value |

## Verification
The bench sweeps all sixteen control codes in bits 3:0, with several reload values each, and compares count and irq in every cycle against an arithmetic model. This sweep exposes a width decoder with the wrong priority, and a decrement whose borrow runs into the frozen upper bits. Directed cases cover the 4-bit wrap from 0xABC0 to 0xABCF with irq raised. They also cover irq staying high across further ticks, ticks while disabled, and strobes or control writes that land on a zero-reaching tick. A design that lets the tick win in that last case would leave irq set or change the counter. The bench also issues a reload strobe together with a nibble write. A design that forwards the new nibble into that strobe would load the wrong value.

// File: rtl/mit_pkg.sv
`timescale 1ns/1ps
package mit_pkg;
  // Strobes that the control path hands to the counter datapath each cycle.
  typedef struct packed {
    logic load;   // copy reload value into the counter
    logic clear;  // drop the pending interrupt
    logic step;   // perform one masked decrement
  } cntStrobes_t;
endpackage

// File: rtl/mit_ctrl.sv
`timescale 1ns/1ps
module mit_ctrl
  import mit_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4,
  parameter int DATA_W  = 8,
  localparam int CNT_W  = NIB_W * NUM_NIB,
  localparam int IDX_W  = $clog2(NUM_NIB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              relWr,
  input  logic [IDX_W-1:0]  relIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              relLoad,
  input  logic              ctrlWr,
  output cntStrobes_t       strobes,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  mask,
  output logic              enable
);
  logic [IDX_W-1:0] dropSel;     // number of upper nibbles frozen
  logic [IDX_W-1:0] dropSelNext;
  logic             enReg;

  // Highest set bit among wrData[NUM_NIB-1:1] wins.
  always_comb begin
    dropSelNext = '0;
    for (int b = 1; b < NUM_NIB; b++) begin
      if (wrData[b]) dropSelNext = IDX_W'(b);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      dropSel <= '0;
    end else if (ctrlWr) begin
      enReg   <= wrData[0];
      dropSel <= dropSelNext;
    end
  end

  for (genvar i = 0; i < NUM_NIB; i++) begin : g_nib
    logic [NIB_W-1:0] relNib;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        relNib <= '0;
      end else if (relWr && (relIdx == IDX_W'(i))) begin
        relNib <= wrData[NIB_W-1:0];
      end
    end
    assign loadVal[i*NIB_W +: NIB_W] = relNib;
    assign mask[i*NIB_W +: NIB_W]    = {NIB_W{(i + int'(dropSel)) < NUM_NIB}};
  end

  assign enable        = enReg;
  assign strobes.load  = relLoad;
  assign strobes.clear = relLoad | ctrlWr;
  assign strobes.step  = tick & enReg & ~relLoad & ~ctrlWr;
endmodule

// File: rtl/mit_datapath.sv
`timescale 1ns/1ps
module mit_datapath
  import mit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobes_t      strobes,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] mask,
  output logic [CNT_W-1:0] count,
  output logic             irq
);
  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] maskedCnt;
  logic [CNT_W-1:0] stepVal;
  logic             zeroHit;

  assign maskedCnt = cntReg & mask;
  assign zeroHit   = (maskedCnt == '0);
  assign stepVal   = (cntReg & ~mask) | ((maskedCnt - 1'b1) & mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (strobes.load) begin
      cntReg <= loadVal;
    end else if (strobes.step) begin
      cntReg <= stepVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq <= 1'b0;
    end else if (strobes.clear) begin
      irq <= 1'b0;
    end else if (strobes.step && zeroHit) begin
      irq <= 1'b1;
    end
  end

  assign count = cntReg;
endmodule

// File: rtl/masked_irq_timer.sv
`timescale 1ns/1ps
module masked_irq_timer
  import mit_pkg::*;
#(
  parameter int NIB_W   = 4,
  parameter int NUM_NIB = 4,
  parameter int DATA_W  = 8,
  localparam int CNT_W  = NIB_W * NUM_NIB,
  localparam int IDX_W  = $clog2(NUM_NIB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              relWr,
  input  logic [IDX_W-1:0]  relIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              relLoad,
  input  logic              ctrlWr,
  output logic              irq,
  output logic [CNT_W-1:0]  count
);
  cntStrobes_t      strobes;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] mask;
  logic             enable;

  mit_ctrl #(.NIB_W(NIB_W), .NUM_NIB(NUM_NIB), .DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .relWr   (relWr),
    .relIdx  (relIdx),
    .wrData  (wrData),
    .relLoad (relLoad),
    .ctrlWr  (ctrlWr),
    .strobes (strobes),
    .loadVal (loadVal),
    .mask    (mask),
    .enable  (enable)
  );

  mit_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .loadVal (loadVal),
    .mask    (mask),
    .count   (count),
    .irq     (irq)
  );
endmodule

// File: rtl/mit_checker.sv
`timescale 1ns/1ps
module mit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             relLoad,
  input logic             ctrlWr,
  input logic             enable,
  input logic [CNT_W-1:0] mask,
  input logic [CNT_W-1:0] loadVal,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  logic liveTick;
  assign liveTick = tick && enable && !relLoad && !ctrlWr;

  // R3
  a_r3_load_value: assert property (@(posedge clk) disable iff (!rstN)
    relLoad |=> (count == $past(loadVal)));

  // R3 R4 R10
  a_r4_clear_irq: assert property (@(posedge clk) disable iff (!rstN)
    (relLoad || ctrlWr) |=> !irq);

  // R6
  a_r6_upper_frozen: assert property (@(posedge clk) disable iff (!rstN)
    liveTick |=> ((count & ~$past(mask)) == ($past(count) & ~$past(mask))));

  // R6
  a_r6_masked_dec: assert property (@(posedge clk) disable iff (!rstN)
    liveTick |=> ((count & $past(mask)) ==
                  ((($past(count) & $past(mask)) - 1'b1) & $past(mask))));

  // R7
  a_r7_zero_raise: assert property (@(posedge clk) disable iff (!rstN)
    (liveTick && ((count & mask) == '0)) |=> irq);

  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !relLoad && !ctrlWr) |=> irq);

  // R9
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(tick && enable) && !relLoad) |=> $stable(count));

  // R9
  a_r9_no_raise: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !(tick && enable)) |=> !irq);
endmodule

bind masked_irq_timer mit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tick    (tick),
  .relLoad (relLoad),
  .ctrlWr  (ctrlWr),
  .enable  (enable),
  .mask    (mask),
  .loadVal (loadVal),
  .count   (count),
  .irq     (irq)
);

// File: tb/test_masked_irq_timer.sv
`timescale 1ns/1ps
module test_masked_irq_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        relWr = 1'b0;
  logic [1:0]  relIdx = '0;
  logic [7:0]  wrData = '0;
  logic        relLoad = 1'b0;
  logic        ctrlWr = 1'b0;
  logic        irq;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference state derived from the requirements.
  logic [15:0] mCnt;
  logic        mIrq;
  logic        mEn;
  logic [15:0] mMask;
  logic [3:0]  mRel [4];

  always #2.5 clk = ~clk;

  masked_irq_timer i_masked_irq_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .relWr(relWr), .relIdx(relIdx),
    .wrData(wrData), .relLoad(relLoad), .ctrlWr(ctrlWr), .irq(irq), .count(count)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // R5 width encoding
  function automatic logic [15:0] maskOf(input logic [7:0] d);
    if (d[3])      return 16'h000F;
    else if (d[2]) return 16'h00FF;
    else if (d[1]) return 16'h0FFF;
    else           return 16'hFFFF;
  endfunction

  // Called at a falling edge; drives, waits one rising edge, checks.
  task automatic cyc(input string tag, input logic t, input logic rw,
                     input logic [1:0] idx, input logic [7:0] d,
                     input logic rs, input logic cw);
    logic [15:0] mv;
    tick = t; relWr = rw; relIdx = idx; wrData = d; relLoad = rs; ctrlWr = cw;
    @(posedge clk);
    if (rs) begin
      mCnt = {mRel[3], mRel[2], mRel[1], mRel[0]};
      mIrq = 1'b0;
    end else if (cw) begin
      mIrq = 1'b0;
    end else if (t && mEn) begin
      mv = mCnt & mMask;
      if (mv == 16'h0) mIrq = 1'b1;
      mCnt = (mCnt & ~mMask) | ((mv - 16'h1) & mMask);
    end
    if (cw) begin
      mEn = d[0];
      mMask = maskOf(d);
    end
    if (rw) mRel[idx] = d[3:0];
    #1;
    chk({tag, " count"}, 32'(count), 32'(mCnt));
    chk({tag, " irq"}, 32'(irq), 32'(mIrq));
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n, input logic t);
    for (int k = 0; k < n; k++) cyc(tag, t, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic writeRel(input logic [15:0] v);
    for (int k = 0; k < 4; k++) begin
      logic [3:0] nb;
      nb = v[k*4 +: 4];
      cyc("R2 nibble write", 1'b0, 1'b1, 2'(k), {~nb, nb}, 1'b0, 1'b0);
    end
  endtask

  task automatic strobe(input string tag);
    cyc(tag, 1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
  endtask

  task automatic ctrl(input string tag, input logic [7:0] d);
    cyc(tag, 1'b0, 1'b0, 2'd0, d, 1'b0, 1'b1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] vals [4];
    vals[0] = 16'h0002; vals[1] = 16'h1230; vals[2] = 16'hF001; vals[3] = 16'h8000;
    mCnt = '0; mIrq = 1'b0; mEn = 1'b0; mMask = 16'hFFFF;
    for (int k = 0; k < 4; k++) mRel[k] = 4'h0;

    repeat (3) @(negedge clk);
    chk("R1 reset count", 32'(count), 32'h0);
    chk("R1 reset irq", 32'(irq), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    idle("R1 disabled after reset", 4, 1'b1);
    strobe("R1 zero reload");
    chk("R1 reload regs zero", 32'(count), 32'h0);

    // R2 / R3 directed
    writeRel(16'h1234);
    strobe("R3 strobe");
    chk("R2 R3 assembled", 32'(count), 32'h1234);

    // R3: strobe coinciding with a nibble write uses the old nibble
    cyc("R3 same-cycle write", 1'b0, 1'b1, 2'd0, 8'h0F, 1'b1, 1'b0);
    chk("R3 old nibble used", 32'(count), 32'h1234);
    strobe("R3 new nibble");
    chk("R3 new nibble seen", 32'(count), 32'h123F);

    // R5 / R6 / R7 sweep over every control code and several reloads
    for (int c = 0; c < 16; c++) begin
      for (int v = 0; v < 4; v++) begin
        ctrl("R5 ctrl", 8'(c << 4) | 8'(c) | 8'h01);
        writeRel(vals[v]);
        strobe("R3 sweep load");
        idle("R6 R7 sweep", 20, 1'b1);
      end
    end

    // R6 / R7 / R8 directed: 4-bit mode
    ctrl("R5 4-bit", 8'h0F);
    writeRel(16'hABC1);
    strobe("R3 load ABC1");
    idle("R6 step", 1, 1'b1);
    chk("R6 4-bit step", 32'(count), 32'hABC0);
    chk("R7 no irq yet", 32'(irq), 32'h0);
    idle("R7 wrap", 1, 1'b1);
    chk("R7 wrap value", 32'(count), 32'hABCF);
    chk("R7 irq raised", 32'(irq), 32'h1);
    idle("R8 sticky", 5, 1'b1);
    chk("R8 irq held", 32'(irq), 32'h1);
    idle("R8 sticky no tick", 3, 1'b0);
    chk("R8 irq held idle", 32'(irq), 32'h1);
    ctrl("R4 clear", 8'h09);
    chk("R4 irq cleared", 32'(irq), 32'h0);

    // R9 disabled
    ctrl("R4 disable", 8'h08);
    idle("R9 disabled ticks", 40, 1'b1);
    chk("R9 count held", 32'(count), 32'hABCA);
    chk("R9 no irq", 32'(irq), 32'h0);

    // R10: control write on a zero-reaching tick
    ctrl("R4 enable 8-bit", 8'h05);
    writeRel(16'h7700);
    strobe("R3 load 7700");
    cyc("R10 ctrl vs tick", 1'b1, 1'b0, 2'd0, 8'h05, 1'b0, 1'b1);
    chk("R10 ctrl wins count", 32'(count), 32'h7700);
    chk("R10 ctrl wins irq", 32'(irq), 32'h0);
    cyc("R10 strobe vs tick", 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    chk("R10 strobe wins count", 32'(count), 32'h7700);
    chk("R10 strobe wins irq", 32'(irq), 32'h0);
    idle("R7 8-bit wrap", 1, 1'b1);
    chk("R7 8-bit wrap value", 32'(count), 32'h77FF);
    chk("R7 8-bit irq", 32'(irq), 32'h1);
    cyc("R10 strobe clears on tick", 1'b1, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0);
    chk("R10 irq dropped", 32'(irq), 32'h0);

    // R5 16-bit: full-width wrap
    ctrl("R5 16-bit", 8'h01);
    writeRel(16'h0000);
    strobe("R3 load 0");
    idle("R7 16-bit wrap", 1, 1'b1);
    chk("R7 16-bit wrap value", 32'(count), 32'hFFFF);
    chk("R7 16-bit irq", 32'(irq), 32'h1);
    idle("R6 tail", 4, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule